// File: doc/BRIEF.md
# SPI Master with Split Transmit and Receive Counts

This block is a SPI master engine that runs a single transfer each time it sees a start strobe. Software programs a transmit byte count and a receive byte count independently of each other. The engine clocks as many bytes on the bus as the larger of the two counts. While transmit bytes remain, it pulls them from a byte-stream source port that uses a valid/ready handshake. After the transmit count is used up, it shifts out a programmable fill byte instead. Received bytes go out on a byte-stream sink port while the receive count lasts. Any received bytes after that are dropped.

When both directions are finished, the engine raises a sticky completion flag and reports how many bytes it took from the source and how many it delivered to the sink. Clock polarity and clock phase select one of the four SPI modes. An even divider sets the SCK rate. Data moves most significant bit first.

Top module: `spim_split_count`

## Requirements
- R1: A one-cycle `startPulse` latches `txLen`, `rxLen`, `cpha` and `clkDiv`, and starts a transfer. Each length may be any value from 0 to 255. Changing the length inputs during a transfer has no effect on it. With both lengths zero, `endEvent` rises on the next cycle and no SCK edge occurs.
- R2: The number of bytes clocked on the bus equals max(`txLen`, `rxLen`).
- R3: Byte k, counting from 0, carries the k-th source byte while k < `txLen`. From k = `txLen` on, every byte carries the value of `overRead`.
- R4: Only the first `rxLen` received bytes appear on `rxData`. Each one is marked by a single-cycle `rxValid` pulse, and later received bytes produce no pulse.
- R5: `endEvent` stays low while a transfer is in progress. It rises once both directions are finished. It then stays high until an `endClear` pulse, or until the next accepted start.
- R6: When a transfer finishes, `txAmount` equals the latched `txLen` and `rxAmount` equals the latched `rxLen`. Both are 0 right after a start.
- R7: MOSI carries each byte MSB first, valid on the capture edge of the selected mode. The leading SCK edge is the move away from the `cpol` level. Capture happens on the leading edge when `cpha` = 0 and on the trailing edge when `cpha` = 1. Between transfers SCK rests at `cpol`.
- R8: The SCK period is `clkDiv` system clocks, for an even `clkDiv` of at least 2.
- R9: `txReady` is raised only while the engine waits for the next byte to send. The source never sees more than `txLen` accepted handshakes per transfer, and a low `txValid` stalls the bus.
- R10: `busy` is high from the cycle after an accepted start until `endEvent` is set. A `startPulse` while `busy` is high is ignored.
- R11: MISO is sampled on the capture edge of the selected mode, MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle transfer start |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| clkDiv | input | 8 | SCK period in system clocks (even, at least 2) |
| txLen | input | 8 | Bytes to take from the source port |
| rxLen | input | 8 | Bytes to deliver on the sink port |
| overRead | input | 8 | Fill byte sent after the source count is used up |
| txData | input | 8 | Source byte |
| txValid | input | 1 | Source byte available |
| txReady | output | 1 | Engine takes the source byte this cycle |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| endClear | input | 1 | Clears `endEvent` |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| txAmount | output | 8 | Source bytes taken in this transfer |
| rxAmount | output | 8 | Bytes delivered in this transfer |
| endEvent | output | 1 | Sticky completion flag |
| busy | output | 1 | Transfer in progress |

## Verification
The bench uses a serial slave model that samples MOSI on its own capture edge and drives MISO as the inverse of MOSI. The captured byte stream therefore checks the mode timing and the fill logic, and the received stream checks the master's own sampling edge.

The length pairs cover four cases, and each one exposes a different fault:
- equal lengths
- a short transmit count, which exposes fill errors
- a short receive count, which exposes discard errors
- one count at zero, which exposes errors in the bus byte count and the end condition

A stalled source checks the handshake. A large divider checks the SCK period. Directed cases cover a zero/zero start, a start while busy, and a 255-byte receive-only transfer.

// File: rtl/spim_split_pkg.sv
package spim_split_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RUN,
    ST_BYTEEND
  } xferState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadPort;  // load shifter from source port
    logic loadFill;  // load shifter with fill byte
    logic sckEdge;   // toggle SCK
    logic shiftOut;  // advance MOSI shifter
    logic sampleIn;  // capture MISO
    logic emitRx;    // present received byte
  } xferStrobe_t;

endpackage

// File: rtl/spim_split_ctrl.sv
module spim_split_ctrl
  import spim_split_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             cpha,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [LEN_W-1:0] txLen,
  input  logic [LEN_W-1:0] rxLen,
  input  logic             txValid,
  output logic             txReady,
  input  logic             endClear,
  output xferStrobe_t      strobe,
  output logic [LEN_W-1:0] txAmount,
  output logic [LEN_W-1:0] rxAmount,
  output logic             endEvent,
  output logic             busy
);

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  xferState_t       state;
  logic [LEN_W-1:0] txLenQ, rxLenQ, totalQ, byteCnt, txCnt, rxCnt;
  logic [DIV_W-1:0] halfQ, tickCnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic             cphaQ, endQ;

  logic             txPending, rxPending, edgeNow, evenEdge;
  logic             startOk, lastByte, endSet;
  logic [LEN_W-1:0] maxLen;

  always_comb begin
    txPending = txCnt < txLenQ;
    rxPending = rxCnt < rxLenQ;
    startOk   = startPulse && (state == ST_IDLE);
    maxLen    = (txLen > rxLen) ? txLen : rxLen;
    edgeNow   = (state == ST_RUN) && (tickCnt == halfQ - 1'b1);
    evenEdge  = ~edgeIdx[0];
    lastByte  = (LEN_W'(byteCnt + 1'b1) == totalQ);
    txReady   = (state == ST_FETCH) && txPending;

    strobe.loadPort = txReady && txValid;
    strobe.loadFill = (state == ST_FETCH) && !txPending;
    strobe.sckEdge  = edgeNow;
    strobe.sampleIn = edgeNow && (evenEdge ^ cphaQ);
    strobe.shiftOut = edgeNow && (evenEdge == cphaQ) &&
                      (cphaQ ? (edgeIdx != '0) : (edgeIdx != LAST_EDGE));
    strobe.emitRx   = (state == ST_BYTEEND) && rxPending;

    endSet = ((state == ST_BYTEEND) && lastByte) || (startOk && (maxLen == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      txLenQ  <= '0;
      rxLenQ  <= '0;
      totalQ  <= '0;
      halfQ   <= DIV_W'(1);
      cphaQ   <= 1'b0;
      tickCnt <= '0;
      edgeIdx <= '0;
      byteCnt <= '0;
      txCnt   <= '0;
      rxCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            txLenQ  <= txLen;
            rxLenQ  <= rxLen;
            totalQ  <= maxLen;
            halfQ   <= (clkDiv < DIV_W'(2)) ? DIV_W'(1) : (clkDiv >> 1);
            cphaQ   <= cpha;
            txCnt   <= '0;
            rxCnt   <= '0;
            byteCnt <= '0;
            state   <= (maxLen == '0) ? ST_IDLE : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (strobe.loadPort || strobe.loadFill) begin
            txCnt   <= txCnt + LEN_W'(strobe.loadPort);
            tickCnt <= '0;
            edgeIdx <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (edgeNow) begin
            tickCnt <= '0;
            edgeIdx <= edgeIdx + 1'b1;
            if (edgeIdx == LAST_EDGE) state <= ST_BYTEEND;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_BYTEEND: begin
          if (rxPending) rxCnt <= rxCnt + 1'b1;
          byteCnt <= byteCnt + 1'b1;
          state   <= lastByte ? ST_IDLE : ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     endQ <= 1'b0;
    else if (endSet)               endQ <= 1'b1;
    else if (startOk || endClear)  endQ <= 1'b0;
  end

  assign txAmount = txCnt;
  assign rxAmount = rxCnt;
  assign endEvent = endQ;
  assign busy     = (state != ST_IDLE);

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (endEvent && !endClear && !startPulse) |=> endEvent);  // R5
  AST_END_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !endEvent);  // R5
  AST_BUSY_FALL_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> endEvent);  // R10
  AST_TX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    txAmount <= txLenQ);  // R9
  AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rxAmount <= rxLenQ);  // R4
  AST_AMOUNTS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (txAmount == '0 && rxAmount == '0));  // R6

endmodule

// File: rtl/spim_split_datapath.sv
module spim_split_datapath
  import spim_split_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic              cpol,
  input  logic [DATA_W-1:0] txData,
  input  logic [DATA_W-1:0] overRead,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  logic              sckLevel;
  logic [DATA_W-1:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckLevel <= 1'b0;
      txShift  <= '0;
      rxShift  <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (strobe.sckEdge) sckLevel <= ~sckLevel;
      if (strobe.loadPort)      txShift <= txData;
      else if (strobe.loadFill) txShift <= overRead;
      else if (strobe.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strobe.sampleIn) rxShift <= {rxShift[DATA_W-2:0], miso};
      rxValid <= strobe.emitRx;
      if (strobe.emitRx) rxData <= rxShift;
    end
  end

  assign sck  = sckLevel ^ cpol;
  assign mosi = txShift[DATA_W-1];

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);  // R4
  AST_MOSI_HOLD_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleIn |-> !strobe.shiftOut);  // R7

endmodule

// File: rtl/spim_split_count.sv
module spim_split_count
  import spim_split_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [LEN_W-1:0]  txLen,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic [DATA_W-1:0] overRead,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              endClear,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [LEN_W-1:0]  txAmount,
  output logic [LEN_W-1:0]  rxAmount,
  output logic              endEvent,
  output logic              busy
);

  xferStrobe_t strobe;

  spim_split_ctrl #(.LEN_W(LEN_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cpha(cpha),
    .clkDiv(clkDiv), .txLen(txLen), .rxLen(rxLen), .txValid(txValid),
    .txReady(txReady), .endClear(endClear), .strobe(strobe),
    .txAmount(txAmount), .rxAmount(rxAmount), .endEvent(endEvent), .busy(busy)
  );

  spim_split_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpol(cpol), .txData(txData),
    .overRead(overRead), .miso(miso), .sck(sck), .mosi(mosi),
    .rxData(rxData), .rxValid(rxValid)
  );

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sck == cpol));  // R7
  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> busy);  // R9

endmodule

// File: tb/spim_split_count_tb.sv
module spim_split_count_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [7:0] div;
    logic [7:0] txL;
    logic [7:0] rxL;
    logic [7:0] orc;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 8'd2, 8'd3, 8'd3, 8'hA5},
    '{1'b0, 1'b1, 8'd4, 8'd2, 8'd4, 8'h3C},
    '{1'b1, 1'b0, 8'd2, 8'd4, 8'd1, 8'hFF},
    '{1'b1, 1'b1, 8'd6, 8'd0, 8'd2, 8'h5A},
    '{1'b0, 1'b0, 8'd2, 8'd2, 8'd0, 8'h00},
    '{1'b1, 1'b1, 8'd2, 8'd1, 8'd1, 8'hC3}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic startPulse = 1'b0, endClear = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0;
  logic [7:0] clkDiv = 8'd2, txLen = '0, rxLen = '0, overRead = '0;
  logic [7:0] txData, rxData, txAmount, rxAmount;
  logic txValid, txReady, rxValid, sck, mosi, miso, endEvent, busy;

  int curVec = 0;
  logic stallMode = 1'b0;
  logic monClr = 1'b0;
  int txIdx = 0, cyc = 0;
  int nChk = 0, nFail = 0;

  logic [7:0] slvBytes [32];
  logic [7:0] rxGot [32];
  int slvN = 0, rxN = 0, rxDouble = 0, bitCnt = 0, nLead = 0;
  int leadStamp [2];
  logic [7:0] shreg = '0;
  logic prevSck = 1'b0, prevRxV = 1'b0;

  function automatic logic [7:0] txByte(input int v, input int i);
    int t;
    t = v * 37 + i * 29 + 107;
    return 8'(t);
  endfunction

  assign txData  = txByte(curVec, txIdx);
  assign txValid = stallMode ? cyc[0] : 1'b1;
  assign miso    = ~mosi;

  spim_split_count u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cpol(cpol), .cpha(cpha),
    .clkDiv(clkDiv), .txLen(txLen), .rxLen(rxLen), .overRead(overRead),
    .txData(txData), .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .endClear(endClear), .sck(sck), .mosi(mosi), .miso(miso),
    .txAmount(txAmount), .rxAmount(rxAmount), .endEvent(endEvent), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // source port model and cycle counter
  initial begin
    forever begin
      @(posedge clk);
      cyc <= cyc + 1;
      if (monClr) txIdx <= 0;
      else if (txReady && txValid) txIdx <= txIdx + 1;
    end
  end

  // serial slave and sink monitor
  initial begin
    forever begin
      @(negedge clk);
      if (monClr) begin
        slvN = 0; rxN = 0; rxDouble = 0; bitCnt = 0; nLead = 0;
        shreg = '0; prevSck = sck; prevRxV = 1'b0;
      end else begin
        if (rxValid) begin
          if (rxN < 32) rxGot[rxN] = rxData;
          rxN++;
          if (prevRxV) rxDouble++;
        end
        prevRxV = rxValid;
        if (sck !== prevSck) begin
          automatic logic lead = (sck !== cpol);
          if (lead && nLead < 2) begin
            leadStamp[nLead] = cyc;
            nLead++;
          end
          if (lead != cpha) begin
            shreg = {shreg[6:0], mosi};
            bitCnt++;
            if (bitCnt == 8) begin
              if (slvN < 32) slvBytes[slvN] = shreg;
              slvN++;
              bitCnt = 0;
            end
          end
          prevSck = sck;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(negedge clk); monClr = 1'b1;
    @(negedge clk);
    @(negedge clk); monClr = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
  endtask

  task automatic waitEnd();
    int n = 0;
    while (!endEvent && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!endEvent) chk("R5 end timeout", 0, 1);
  endtask

  task automatic runVec(input vec_t vv, input int v, input logic stall);
    int total, expB;
    curVec = v;
    stallMode = stall;
    cpol = vv.cpol; cpha = vv.cpha; clkDiv = vv.div;
    txLen = vv.txL; rxLen = vv.rxL; overRead = vv.orc;
    clearMon();
    total = (vv.txL > vv.rxL) ? int'(vv.txL) : int'(vv.rxL);
    pulseStart();
    repeat (3) @(negedge clk);
    chk("R10 busy during transfer", int'(busy), 1);
    chk("R5 end low during transfer", int'(endEvent), 0);
    waitEnd();
    @(negedge clk);
    chk("R2 bytes on bus", slvN, total);
    for (int i = 0; i < total && i < 32; i++) begin
      expB = (i < int'(vv.txL)) ? int'(txByte(v, i)) : int'(vv.orc);
      chk((i < int'(vv.txL)) ? "R7 MOSI byte" : "R3 fill byte", int'(slvBytes[i]), expB);
      if (i < int'(vv.rxL)) chk("R11 MISO byte", int'(rxGot[i]), expB ^ 8'hFF);
    end
    chk("R4 rx byte count", rxN, int'(vv.rxL));
    chk("R4 rxValid single pulse", rxDouble, 0);
    chk("R6 txAmount", int'(txAmount), int'(vv.txL));
    chk("R6 rxAmount", int'(rxAmount), int'(vv.rxL));
    chk("R9 source handshakes", txIdx, int'(vv.txL));
    chk("R7 sck idle", int'(sck), int'(vv.cpol));
    chk("R10 busy after end", int'(busy), 0);
    if (total > 0) chk("R8 sck period", leadStamp[1] - leadStamp[0], int'(vv.div));
    repeat (3) @(negedge clk);
    chk("R5 end sticky", int'(endEvent), 1);
    endClear = 1'b1;
    @(negedge clk); endClear = 1'b0;
    chk("R5 end cleared", int'(endEvent), 0);
    stallMode = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R10 busy at reset", int'(busy), 0);
    chk("R5 end at reset", int'(endEvent), 0);
    chk("R4 rxValid at reset", int'(rxValid), 0);
    chk("R7 sck at reset", int'(sck), 0);
    chk("R9 txReady at reset", int'(txReady), 0);

    // main table
    for (int v = 0; v < NVEC; v++) runVec(VECS[v], v, v == 1);

    // R1: zero/zero ends at once with no clocking
    txLen = 0; rxLen = 0; cpol = 1'b0; cpha = 1'b0; clkDiv = 8'd2;
    clearMon();
    pulseStart();
    chk("R1 zero lengths end", int'(endEvent), 1);
    chk("R1 zero lengths busy", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R1 zero lengths no bytes", slvN, 0);
    endClear = 1'b1; @(negedge clk); endClear = 1'b0;

    // R10 and R1: start while busy ignored, lengths latched
    curVec = 7; txLen = 2; rxLen = 2; clkDiv = 8'd4; overRead = 8'h11;
    clearMon();
    pulseStart();
    repeat (10) @(negedge clk);
    txLen = 5; rxLen = 5;
    pulseStart();
    waitEnd();
    @(negedge clk);
    chk("R10 start while busy ignored", slvN, 2);
    chk("R1 latched txLen", int'(txAmount), 2);
    chk("R1 latched rxLen", int'(rxAmount), 2);
    repeat (4) @(negedge clk);
    chk("R10 no restart", int'(busy), 0);
    endClear = 1'b1; @(negedge clk); endClear = 1'b0;

    // R1: full-range receive-only length
    curVec = 8; txLen = 0; rxLen = 255; clkDiv = 8'd2; overRead = 8'h96;
    cpol = 1'b1; cpha = 1'b0;
    clearMon();
    pulseStart();
    waitEnd();
    @(negedge clk);
    chk("R1 255 bytes on bus", slvN, 255);
    chk("R1 255 rxAmount", int'(rxAmount), 255);
    chk("R1 255 rx strobes", rxN, 255);
    chk("R3 fill at byte 31", int'(slvBytes[31]), 8'h96);
    chk("R9 no source pulls", txIdx, 0);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule